// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block treats a 64-bit word as a packed row of equal-width lanes and rearranges those lanes under the control of a second 64-bit word. That second word holds one index per lane. A size select picks the lane width at run time: 8-bit, 16-bit or 32-bit lanes, which gives 8, 4 or 2 lanes. The block copies lane contents unchanged. Every output lane has the same width as an input lane, and the lanes are packed back into a single 64-bit result.

There are two directions. In pull mode, each output lane fetches the input lane that its own index names. In push mode, each input lane is written into the output lane that its index names. Indices may repeat, so the result can hold duplicates. In push mode, when several input lanes name the same destination, the input lane with the highest number wins. Any output lane that no input lane names becomes zero. The result is registered, and `res_vld` marks it one clock after `req_vld`.

Top module: `lane_shuffle`

## Requirements
- R1: In pull mode (`dir`=0), output lane i equals input lane `idx[i]` for every lane i. Lane i is bits [i*W +: W], where W is 8, 16 or 32.
- R2: In push mode (`dir`=1), output lane `idx[i]` receives input lane i.
- R3: Repeated index values are allowed. In pull mode, several output lanes may carry copies of the same input lane.
- R4: In push mode, when several input lanes target the same output lane, the lane with the highest i wins.
- R5: In push mode, an output lane that no index targets reads zero.
- R6: `esz` encodes the lane width as 0 = 8 bits (8 lanes), 1 = 16 bits (4 lanes), and 2 or 3 = 32 bits (2 lanes).
- R7: Each index field uses only the low log2(lanes) bits of its lane in the index word. Its upper bits have no effect.
- R8: `res_vld` equals `req_vld` delayed by exactly one clock. `res` is the result for the inputs sampled on that edge.
- R9: A synchronous active-high `rst` clears `res_vld` and `res`.
- R10: With identity indices (lane i holds i), both modes return the input word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| dir | input | 1 | 0 = pull by index, 1 = push by index |
| esz | input | 2 | Lane width select |
| src | input | 64 | Packed source lanes |
| idx | input | 64 | Packed per-lane indices |
| res | output | 64 | Registered packed result |
| res_vld | output | 1 | Result valid |

## Verification
Any fault in the lane decode or in the select network shows up in `res` in the cycle right after the request, because no state outlives a single transfer. A wrong winner in a push collision, or a missing zero fill, shows up only in push mode with colliding or sparse indices. The bench builds those index patterns on purpose. A fault in the valid pipeline shows up as `res_vld` shifted by one cycle in relation to `req_vld`.

// File: rtl/lane_shuffle.sv
module lane_shuffle #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic          dir,
  input  logic [1:0]    esz,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] idx,
  output logic [DW-1:0] res,
  output logic          res_vld
);
  localparam int N8  = DW / 8;
  localparam int N16 = DW / 16;
  localparam int N32 = DW / 32;

  function automatic logic [DW-1:0] shuffle8(input logic d, input logic [DW-1:0] s,
                                             input logic [DW-1:0] x);
    logic [DW-1:0] r;
    logic [$clog2(N8)-1:0] k;
    r = '0;
    for (int i = 0; i < N8; i++) begin
      k = x[i*8 +: $clog2(N8)];
      if (!d) r[i*8 +: 8] = s[k*8 +: 8];
      else    r[k*8 +: 8] = s[i*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] shuffle16(input logic d, input logic [DW-1:0] s,
                                              input logic [DW-1:0] x);
    logic [DW-1:0] r;
    logic [$clog2(N16)-1:0] k;
    r = '0;
    for (int i = 0; i < N16; i++) begin
      k = x[i*16 +: $clog2(N16)];
      if (!d) r[i*16 +: 16] = s[k*16 +: 16];
      else    r[k*16 +: 16] = s[i*16 +: 16];
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] shuffle32(input logic d, input logic [DW-1:0] s,
                                              input logic [DW-1:0] x);
    logic [DW-1:0] r;
    logic [$clog2(N32)-1:0] k;
    r = '0;
    for (int i = 0; i < N32; i++) begin
      k = x[i*32 +: $clog2(N32)];
      if (!d) r[i*32 +: 32] = s[k*32 +: 32];
      else    r[k*32 +: 32] = s[i*32 +: 32];
    end
    return r;
  endfunction

  logic [DW-1:0] nxt;

  always_comb begin
    case (esz)
      2'd0:    nxt = shuffle8(dir, src, idx);
      2'd1:    nxt = shuffle16(dir, src, idx);
      default: nxt = shuffle32(dir, src, idx);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= req_vld;
      if (req_vld) res <= nxt;
    end
  end
endmodule

// File: rtl/lane_shuffle_chk.sv
module lane_shuffle_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_vld,
  input logic        dir,
  input logic [1:0]  esz,
  input logic [63:0] src,
  input logic [63:0] idx,
  input logic [63:0] res,
  input logic        res_vld
);
  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (rst) req_vld |=> res_vld); // R8
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (rst) !req_vld |=> !res_vld); // R8
  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (!res_vld && res == 64'd0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !req_vld |=> $stable(res)); // R8
  AST_ID_PULL8: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !dir && esz == 2'd0 && idx == 64'h0706050403020100) |=> res == $past(src)); // R10
  AST_ID_PUSH16: assert property (@(posedge clk) disable iff (rst)
    (req_vld && dir && esz == 2'd1 && idx == 64'h0003000200010000) |=> res == $past(src)); // R10
  AST_PUSH_SAME32: assert property (@(posedge clk) disable iff (rst)
    (req_vld && dir && esz[1] && idx[0] == idx[32]) |=> res[{~$past(idx[0]), 5'd0} +: 32] == 32'd0); // R5
endmodule

bind lane_shuffle lane_shuffle_chk u_chk (
  .clk(clk), .rst(rst), .req_vld(req_vld), .dir(dir), .esz(esz),
  .src(src), .idx(idx), .res(res), .res_vld(res_vld)
);

// File: tb/lane_shuffle_test.sv
module lane_shuffle_test;
  logic clk = 0, rst = 1, req_vld = 0, dir = 0;
  logic [1:0] esz = 0;
  logic [63:0] src = 0, idx = 0;
  logic [63:0] res;
  logic res_vld;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  lane_shuffle uut (.clk(clk), .rst(rst), .req_vld(req_vld), .dir(dir), .esz(esz),
                    .src(src), .idx(idx), .res(res), .res_vld(res_vld));

  function automatic int width_of(input logic [1:0] e);
    return e == 0 ? 8 : (e == 1 ? 16 : 32);
  endfunction

  function automatic logic [63:0] model(input logic d, input logic [1:0] e,
                                        input logic [63:0] s, input logic [63:0] x);
    int w, n, k;
    logic [63:0] r;
    w = width_of(e); n = 64 / w; r = '0;
    for (int i = 0; i < n; i++) begin
      k = int'((x >> (i*w)) & 64'(n-1));
      for (int b = 0; b < w; b++)
        if (!d) r[i*w+b] = s[k*w+b];
        else    r[k*w+b] = s[i*w+b];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic d, input logic [1:0] e, input logic [63:0] s,
                       input logic [63:0] x, input logic [63:0] exp, input string req);
    @(negedge clk);
    dir = d; esz = e; src = s; idx = x; req_vld = 1;
    @(negedge clk);
    req_vld = 0;
    check(req, {63'd0, res_vld}, 64'd1);
    check(req, res, exp);
    check(req, res, model(d, e, s, x));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9", {63'd0, res_vld}, 64'd0);
    check("R9", res, 64'd0);
  endtask

  task automatic t_identity;
    logic [63:0] s = 64'h0123456789ABCDEF;
    issue(0, 0, s, 64'h0706050403020100, s, "R10");
    issue(1, 0, s, 64'h0706050403020100, s, "R10");
    issue(0, 1, s, 64'h0003000200010000, s, "R10");
    issue(1, 2, s, 64'h0000000100000000, s, "R10");
  endtask

  task automatic t_pull;
    issue(0, 0, 64'h8877665544332211, 64'h0001020304050607, 64'h1122334455667788, "R1");
    issue(0, 1, 64'hDDDDCCCCBBBBAAAA, 64'h0000000100020003, 64'hAAAABBBBCCCCDDDD, "R1");
    issue(0, 0, 64'h8877665544332211, 64'h0303030303030303, 64'h4444444444444444, "R3");
  endtask

  task automatic t_push;
    issue(1, 0, 64'h8877665544332211, 64'h0001020304050607, 64'h1122334455667788, "R2");
    issue(1, 1, 64'hDDDDCCCCBBBBAAAA, 64'h0002000200020002, 64'h0000DDDD00000000, "R4");
    issue(1, 0, 64'h8877665544332211, 64'h0000000000000000, 64'h0000000000000088, "R5");
  endtask

  task automatic t_size;
    issue(0, 3, 64'h22222222_11111111, 64'h00000000_00000001, 64'h11111111_22222222, "R6");
    issue(0, 2, 64'h22222222_11111111, 64'h00000001_00000001, 64'h22222222_22222222, "R6");
  endtask

  task automatic t_upper_bits;
    issue(0, 0, 64'h8877665544332211, 64'hF8F9FAFBFCFDFEFF, 64'h1122334455667788, "R7");
    issue(0, 1, 64'hDDDDCCCCBBBBAAAA, 64'hFFFCFFFDFFFEFFFF, 64'hAAAABBBBCCCCDDDD, "R7");
  endtask

  task automatic t_valid_timing;
    @(negedge clk);
    dir = 0; esz = 0; src = 64'hCAFE; idx = 0; req_vld = 1;
    check("R8", {63'd0, res_vld}, 64'd0);
    @(negedge clk);
    req_vld = 0;
    check("R8", {63'd0, res_vld}, 64'd1);
    @(negedge clk);
    check("R8", {63'd0, res_vld}, 64'd0);
    check("R8", res, 64'hFEFEFEFEFEFEFEFE);
  endtask

  task automatic t_reset_mid;
    issue(0, 0, 64'hFFFF, 64'h0, 64'hFFFFFFFFFFFFFFFF, "R1");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R9", {63'd0, res_vld}, 64'd0);
    check("R9", res, 64'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_identity();
        t_pull();
        t_push();
        t_size();
        t_upper_bits();
        t_valid_timing();
        t_reset_mid();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule